// File: doc/BRIEF.md
# CPU-side byte FIFO bus port

This block lets an external processor reach a pair of byte queues over a plain asynchronous microprocessor bus. The bus has an active-low select, one address bit, and active-low read and write strobes. The byte lane is split into `data_i`, `data_o` and `data_oe_o`, and the pad ring that joins them into one bidirectional 8-bit bus lies outside this block. The processor can pop bytes that the device side has received, push bytes for the device side to send, read a status byte, and ask for pending transmit data to be flushed at once.

Strobes and bus fields cross into the local clock through a flop synchroniser. Every action happens once per strobe, on the strobe's release. The read bus value is produced combinationally while the strobe is held, so the processor sees valid data before it releases the strobe. The device side fills the receive queue and drains the transmit queue through simple push and pop ports. It also receives a one-clock flush pulse each time the processor writes to the command address.

Top module: `cpu_fifo_port`

## Requirements
- R1: While `cs_ni` is high, read and write strobes cause no pop, no push and no flush pulse, and `data_oe_o` stays 0.
- R2: With `cs_ni` low and `addr_i`=0, a read strobe presents the oldest receive byte on `data_o`, and releasing the strobe removes that byte.
- R3: With `cs_ni` low and `addr_i`=0, a write strobe appends the value of `data_i`, held during the strobe, to the transmit queue.
- R4: With `cs_ni` low and `addr_i`=1, a read presents the status byte and removes nothing. In that byte, bit 0 = receive data available, bit 1 = transmit space available, bit 2 = `suspend_i`, and bit 3 = `configured_i`. Bits 7:4 are undefined.
- R5: With `cs_ni` low and `addr_i`=1, each write strobe produces exactly one `flush_o` pulse, one clock wide and generated from the local clock, and pushes nothing.
- R6: `data_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both low.
- R7: A data write while the transmit queue holds `FIFO_DEPTH` bytes is discarded.
- R8: A data read from an empty receive queue returns 0x00 and leaves the queue pointers unchanged.
- R9: An action is taken once per strobe, on its release. A long strobe does not advance the queue while it is held.
- R10: After reset, both queues are empty, `flush_o` is 0 and `rx_full_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Bus select, active low |
| addr_i | input | 1 | 0 = data pipe, 1 = status/command |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Byte lane from pad |
| data_o | output | 8 | Byte lane to pad |
| data_oe_o | output | 1 | Pad output enable |
| rx_wr_i | input | 1 | Device side pushes a receive byte |
| rx_wdata_i | input | 8 | Receive byte to push |
| rx_full_o | output | 1 | Receive queue full |
| tx_rd_i | input | 1 | Device side pops a transmit byte |
| tx_rdata_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit queue empty |
| suspend_i | input | 1 | Suspend flag for status bit 2 |
| configured_i | input | 1 | Configured flag for status bit 3 |
| flush_o | output | 1 | Send-immediate pulse |

## Verification
On every cycle, the assertions check several local properties. The flush pulse lasts a single clock. A strobe release is detected only once. A full queue stays full under a lone push, and an empty queue stays empty under a lone pop. The bench scenarios are needed for the end-to-end behaviour: byte ordering through both queues, status contents across all flag combinations and fill levels, the dropped byte on an overfull write, and the zero returned by an empty read. They also show that deselected strobes leave the queue contents untouched and that a held strobe does not advance the queue.

// File: rtl/cpu_fifo_pkg.sv
package cpu_fifo_pkg;
  localparam int BUS_W = 8;
  localparam int ST_RX_AVAIL = 0;
  localparam int ST_TX_SPACE = 1;
  localparam int ST_SUSPEND = 2;
  localparam int ST_CONFIG = 3;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } sel_e;

  typedef struct packed {
    logic             cs_n;
    sel_e             sel;
    logic [BUS_W-1:0] data;
  } bus_cap_t;
endpackage

// File: rtl/cpu_bus_sync.sv
module cpu_bus_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cpu_strobe_decode.sv
module cpu_strobe_decode
  import cpu_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_s_i,
  input  logic             wr_s_i,
  input  bus_cap_t         bus_s_i,
  output logic             rx_pop_o,
  output logic             tx_push_o,
  output logic [BUS_W-1:0] tx_data_o,
  output logic             flush_req_o
);
  logic     rd_q, wr_q;
  bus_cap_t cap_q;
  logic     rd_rise, wr_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      cap_q <= '{cs_n: 1'b1, sel: SEL_DATA, data: '0};
    end else begin
      rd_q <= rd_s_i;
      wr_q <= wr_s_i;
      // hold the fields seen while a strobe is active; use them at release
      if (!rd_s_i || !wr_s_i) cap_q <= bus_s_i;
    end
  end

  assign rd_rise = rd_s_i & ~rd_q;
  assign wr_rise = wr_s_i & ~wr_q;

  assign rx_pop_o    = rd_rise & ~cap_q.cs_n & (cap_q.sel == SEL_DATA);
  assign tx_push_o   = wr_rise & ~cap_q.cs_n & (cap_q.sel == SEL_DATA);
  assign flush_req_o = wr_rise & ~cap_q.cs_n & (cap_q.sel == SEL_CTRL);
  assign tx_data_o   = cap_q.data;

  assert_single_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> !rx_pop_o);
endmodule

// File: rtl/cpu_byte_fifo.sv
module cpu_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full_o  = (count == DEPTH_C);
  assign empty_o = (count == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) if (do_push) mem[wptr] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_fill_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= DEPTH_C);
  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);
  assert_empty_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/cpu_fifo_port.sv
module cpu_fifo_port
  import cpu_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             addr_i,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe_o,
  input  logic             rx_wr_i,
  input  logic [BUS_W-1:0] rx_wdata_i,
  output logic             rx_full_o,
  input  logic             tx_rd_i,
  output logic [BUS_W-1:0] tx_rdata_o,
  output logic             tx_empty_o,
  input  logic             suspend_i,
  input  logic             configured_i,
  output logic             flush_o
);
  localparam int SW = BUS_W + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, {BUS_W{1'b0}}, 1'b1, 1'b1};

  logic [SW-1:0]    sync_q;
  bus_cap_t         bus_s;
  logic             rd_s, wr_s;
  logic             rx_pop, tx_push, flush_req;
  logic [BUS_W-1:0] tx_wdata, rx_head, status;
  logic             rx_empty, tx_full;

  cpu_bus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, addr_i, data_i, rd_ni, wr_ni}),
    .q_o (sync_q)
  );

  assign bus_s = bus_cap_t'(sync_q[SW-1:2]);
  assign rd_s  = sync_q[1];
  assign wr_s  = sync_q[0];

  cpu_strobe_decode u_dec (
    .clk_i, .rst_ni,
    .rd_s_i      (rd_s),
    .wr_s_i      (wr_s),
    .bus_s_i     (bus_s),
    .rx_pop_o    (rx_pop),
    .tx_push_o   (tx_push),
    .tx_data_o   (tx_wdata),
    .flush_req_o (flush_req)
  );

  cpu_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BUS_W)) u_rx (
    .clk_i, .rst_ni,
    .push_i  (rx_wr_i),
    .wdata_i (rx_wdata_i),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .full_o  (rx_full_o),
    .empty_o (rx_empty)
  );

  cpu_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BUS_W)) u_tx (
    .clk_i, .rst_ni,
    .push_i  (tx_push),
    .wdata_i (tx_wdata),
    .pop_i   (tx_rd_i),
    .rdata_o (tx_rdata_o),
    .full_o  (tx_full),
    .empty_o (tx_empty_o)
  );

  always_comb begin
    status              = '0;
    status[ST_RX_AVAIL] = ~rx_empty;
    status[ST_TX_SPACE] = ~tx_full;
    status[ST_SUSPEND]  = suspend_i;
    status[ST_CONFIG]   = configured_i;
  end

  assign data_oe_o = ~cs_ni & ~rd_ni;
  assign data_o    = (sel_e'(addr_i) == SEL_CTRL) ? status
                   : (rx_empty ? '0 : rx_head);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flush_o <= 1'b0;
    else         flush_o <= flush_req;

  assert_flush_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

// File: tb/cpu_fifo_port_test.sv
module cpu_fifo_port_test;
  localparam int DEPTH = 4;

  logic       clk_i = 0, rst_ni = 0;
  logic       cs_ni = 1, addr_i = 0, rd_ni = 1, wr_ni = 1;
  logic [7:0] data_i = 0, data_o;
  logic       data_oe_o;
  logic       rx_wr_i = 0;
  logic [7:0] rx_wdata_i = 0;
  logic       rx_full_o;
  logic       tx_rd_i = 0;
  logic [7:0] tx_rdata_o;
  logic       tx_empty_o;
  logic       suspend_i = 0, configured_i = 0;
  logic       flush_o;

  int n_chk = 0, n_fail = 0, flush_cnt = 0, flush_run = 0, flush_max = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cpu_fifo_port #(.FIFO_DEPTH(DEPTH)) uut (.*);

  always @(posedge clk_i) begin
    if (flush_o) begin
      flush_cnt <= flush_cnt + 1;
      flush_run <= flush_run + 1;
      if (flush_run + 1 > flush_max) flush_max <= flush_run + 1;
    end else flush_run <= 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cpu_read(input logic cs, input logic a, input int hold,
                          output logic [7:0] d, output logic oe);
    cs_ni = cs; addr_i = a;
    @(negedge clk_i); rd_ni = 0;
    repeat (hold) @(negedge clk_i);
    d = data_o; oe = data_oe_o;
    rd_ni = 1;
    @(negedge clk_i); cs_ni = 1;
    idle(4);
  endtask

  task automatic cpu_write(input logic cs, input logic a, input logic [7:0] d);
    cs_ni = cs; addr_i = a; data_i = d;
    @(negedge clk_i); wr_ni = 0;
    idle(3);
    wr_ni = 1;
    @(negedge clk_i); cs_ni = 1;
    idle(4);
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_wdata_i = d; rx_wr_i = 1;
    @(negedge clk_i); rx_wr_i = 0;
  endtask

  task automatic tx_pop(output logic [7:0] d, output logic e);
    d = tx_rdata_o; e = tx_empty_o;
    tx_rd_i = 1;
    @(negedge clk_i); tx_rd_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, e;
    idle(3); rst_ni = 1; idle(2);

    // R10 reset state
    chk(!rx_full_o, "R10 rx_full", rx_full_o, 0);
    chk(tx_empty_o, "R10 tx_empty", tx_empty_o, 1);
    chk(!flush_o, "R10 flush", flush_o, 0);
    chk(!data_oe_o, "R10/R6 oe idle", data_oe_o, 0);

    // R4 status sweep over flags, empty queues
    for (int f = 0; f < 4; f++) begin
      suspend_i = f[0]; configured_i = f[1];
      cpu_read(0, 1, 2, d, oe);
      chk(d[3:0] == {f[1], f[0], 2'b10}, "R4 status flags", d[3:0], {f[1], f[0], 2'b10});
      chk(oe, "R6 oe on status read", oe, 1);
    end
    suspend_i = 0; configured_i = 0;

    // R8 empty read returns zero, no pointer move
    cpu_read(0, 0, 2, d, oe);
    chk(d == 8'h00, "R8 empty read", d, 0);
    rx_push(8'h5A);
    cpu_read(0, 0, 2, d, oe);
    chk(d == 8'h5A, "R8 pointer held", d, 8'h5A);

    // R2 fill and drain receive queue, several patterns
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < DEPTH; i++) rx_push(8'((i * 37 + p * 91 + 5) & 8'hFF));
      chk(rx_full_o, "R2 rx full", rx_full_o, 1);
      cpu_read(0, 1, 2, d, oe);
      chk(d[0] == 1'b1, "R4 rx avail", d[0], 1);
      cpu_read(0, 1, 2, d, oe);
      chk(d[0] == 1'b1, "R4 status no pop", d[0], 1);
      for (int i = 0; i < DEPTH; i++) begin
        cpu_read(0, 0, 2, d, oe);
        chk(d == 8'((i * 37 + p * 91 + 5) & 8'hFF), "R2 rx order", d,
            (i * 37 + p * 91 + 5) & 8'hFF);
      end
      cpu_read(0, 1, 2, d, oe);
      chk(d[0] == 1'b0, "R4 rx drained", d[0], 0);
    end

    // R1 deselected strobes do nothing
    rx_push(8'h3C);
    cpu_read(1, 0, 2, d, oe);
    chk(!oe, "R1 oe when deselected", oe, 0);
    cpu_write(1, 0, 8'h77);
    chk(tx_empty_o, "R1 no tx push", tx_empty_o, 1);
    cpu_write(1, 1, 8'h00);
    chk(flush_cnt == 0, "R1 no flush", flush_cnt, 0);
    cpu_read(0, 0, 2, d, oe);
    chk(d == 8'h3C, "R1 rx untouched", d, 8'h3C);

    // R9 long strobe advances once, on release
    rx_push(8'hA1); rx_push(8'hB2);
    cpu_read(0, 0, 12, d, oe);
    chk(d == 8'hA1, "R9 held strobe no advance", d, 8'hA1);
    cpu_read(0, 0, 2, d, oe);
    chk(d == 8'hB2, "R9 single pop", d, 8'hB2);

    // R3/R7 transmit fill, overflow drop, drain
    for (int i = 0; i < DEPTH; i++) cpu_write(0, 0, 8'(8'hC0 + i * 7));
    cpu_read(0, 1, 2, d, oe);
    chk(d[1] == 1'b0, "R7 tx no space", d[1], 0);
    cpu_write(0, 0, 8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      tx_pop(d, e);
      chk(!e && d == 8'(8'hC0 + i * 7), "R3 tx order", d, 8'hC0 + i * 7);
    end
    chk(tx_empty_o, "R7 overflow dropped", tx_empty_o, 1);

    // R5 flush pulses
    for (int i = 0; i < 3; i++) cpu_write(0, 1, 8'h55);
    chk(flush_cnt == 3, "R5 flush count", flush_cnt, 3);
    chk(flush_max == 1, "R5 flush width", flush_max, 1);
    chk(tx_empty_o, "R5 no tx push", tx_empty_o, 1);

    // R6 enable follows select and read only
    cs_ni = 0; addr_i = 0; idle(1);
    chk(!data_oe_o, "R6 oe without read", data_oe_o, 0);
    cs_ni = 1; idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule